// File: doc/BRIEF.md
# Multi-channel edge-aligned PWM generator

This block drives several pulse-width-modulated outputs from one shared up-counter. Software-side logic writes a common modulo value that sets the period, a compare value per channel that sets the pulse length, a polarity bit per channel, and a power-of-two prescale exponent that slows the counting rate. Every output goes active when the counter is at zero and goes inactive when the counter reaches that channel's compare value. The counter then runs up to the modulo value and wraps back to zero.

Compare values are held in a pending copy. They move into the active copy only at a period boundary, so an output never shows a shortened or doubled pulse. A change of period or prescale affects every channel. The block therefore halts the counter for one clock, clears it, and restarts the count from zero. Values that cannot form a legal period or compare are refused at the write port and leave all state as it was.

Top module: `pwm_edge_multi`

## Requirements
- R1: After reset every output is low, `wrap_o` and `wr_rej_o` are low, all compare values are 0, polarity is high-true, the prescale exponent is 0 and the modulo equals the `DEF_MOD` parameter.
- R2: The counter runs from 0 to the modulo M and then wraps to 0. One period therefore lasts (M+1)·2^E clocks, where E is the prescale exponent. `wrap_o` is high for exactly the first clock of each new period.
- R3: An output is active from the first clock of count 0 until the counter equals the channel's compare value C. This gives C·2^E active clocks per period. C = 0 gives 0% duty.
- R4: A compare value above the modulo keeps the output active for the whole period.
- R5: A compare write whose value equals the modulo in force at write time is stored as modulo+1. This gives 100% duty.
- R6: A compare write (`wr_sel` = 1, channel `wr_idx`) takes effect at the next period boundary. A restart also counts as a boundary. The period that is running keeps its old pulse.
- R7: A polarity write (`wr_sel` = 2, `wr_data[0]` = 1 means low-true) inverts the channel's output from the next clock on.
- R8: An accepted period write (`wr_sel` = 0) or prescale write (`wr_sel` = 3, exponent in the low bits of `wr_data`) causes the following sequence. First there is one halt clock, with the counter at 0 and every output at its inactive level. Then counting restarts from 0, with the pending compares loaded.
- R9: A period write of 0, of the counter's all-ones value, or of any larger value is refused. `wr_rej_o` pulses for one clock, and the period in force is kept.
- R10: A compare write above the counter's all-ones value is refused. `wr_rej_o` pulses, and the channel's pulse is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_sel | input | 2 | Target: 0 period, 1 compare, 2 polarity, 3 prescale |
| wr_idx | input | IW | Channel index for compare and polarity writes |
| wr_data | input | CW+1 | Write value, one bit wider than the counter |
| pwm_o | output | NCH | Channel outputs |
| wrap_o | output | 1 | One-clock pulse on the first clock of each period |
| wr_rej_o | output | 1 | One-clock pulse after a refused write |

## Verification
The hardest situation to create from the ports is a compare write that lands inside a running period. To show that the write has no effect, the old pulse must be seen for the rest of that period and the new pulse only in the next one. The bench waits for the `wrap_o` pulse and issues the compare write in that same first clock. It then samples every remaining clock of the period against the old value, and the following period against the new value. Each restart is also checked: the outputs sit at their inactive level for the halt clock, and the first period after the halt starts from count 0 with the pending compares in place.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CMP    = 2'd1,
    SEL_POL    = 2'd2,
    SEL_PSC    = 2'd3
  } wr_sel_e;

  typedef enum logic {
    TB_RUN  = 1'b0,
    TB_HALT = 1'b1
  } tb_state_e;

  // all-ones value of a cw-bit counter, widened
  function automatic logic [32:0] cnt_max(input int unsigned cw);
    return (33'd1 << cw) - 33'd1;
  endfunction

  // a period must be non-zero and strictly below the counter maximum
  function automatic logic period_ok(input logic [32:0] v, input int unsigned cw);
    return (v != 33'd0) && (v < cnt_max(cw));
  endfunction

  // a compare value must fit the counter
  function automatic logic cmp_ok(input logic [32:0] v, input int unsigned cw);
    return v <= cnt_max(cw);
  endfunction

  // pulse equal to period is promoted to period+1 (full duty)
  function automatic logic [31:0] cmp_fix(input logic [31:0] v, input logic [31:0] modv);
    return (v == modv) ? modv + 32'd1 : v;
  endfunction

  // terminal value of the prescale divider for exponent e
  function automatic logic [31:0] div_mask(input int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSW = 3,
  localparam int DIVW = (1 << PSW) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [PSW-1:0] exp_i,
  output logic           tick_o
);
  import pwm_pkg::*;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] term;

  assign term   = DIVW'(div_mask(32'(exp_i)));
  assign tick_o = en_i && (div_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr_i || !en_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic          running_o,
  output logic          wrap_evt_o,
  output logic          wrap_o
);
  import pwm_pkg::*;

  tb_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          wrap_q;

  assign running_o  = (state_q == TB_RUN);
  assign wrap_evt_o = running_o && tick_i && (cnt_q == mod_i);
  assign cnt_o      = cnt_q;
  assign wrap_o     = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TB_RUN;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= wrap_evt_o && !restart_i;
      if (restart_i) begin
        state_q <= TB_HALT;
        cnt_q   <= '0;
      end else if (state_q == TB_HALT) begin
        state_q <= TB_RUN;
      end else if (tick_i) begin
        cnt_q <= wrap_evt_o ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int NCH     = 4,
  parameter int CW      = 16,
  parameter int PSW     = 3,
  parameter int DEF_MOD = 999,
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [IW-1:0]           wr_idx,
  input  logic [CW:0]             wr_data,
  input  logic                    load_i,
  output logic [CW-1:0]           mod_o,
  output logic [NCH-1:0][CW-1:0]  cmp_act_o,
  output logic [NCH-1:0]          pol_o,
  output logic [PSW-1:0]          psc_o,
  output logic                    restart_o,
  output logic                    rej_evt_o,
  output logic                    rej_o
);
  import pwm_pkg::*;

  logic [CW-1:0]          mod_q;
  logic [NCH-1:0][CW-1:0] pend_q;
  logic [NCH-1:0][CW-1:0] act_q;
  logic [NCH-1:0]         pol_q;
  logic [PSW-1:0]         psc_q;
  logic                   rej_q;

  logic sel_per, sel_cmp, sel_pol, sel_psc;
  logic idx_ok, per_bad, cmp_bad, pol_bad;
  logic [CW-1:0] cmp_new;

  always_comb begin
    sel_per = wr_en && (wr_sel == SEL_PERIOD);
    sel_cmp = wr_en && (wr_sel == SEL_CMP);
    sel_pol = wr_en && (wr_sel == SEL_POL);
    sel_psc = wr_en && (wr_sel == SEL_PSC);
    idx_ok  = (32'(wr_idx) < NCH);
    per_bad = sel_per && !period_ok(33'(wr_data), CW);
    cmp_bad = sel_cmp && (!cmp_ok(33'(wr_data), CW) || !idx_ok);
    pol_bad = sel_pol && !idx_ok;
    cmp_new = CW'(cmp_fix(32'(wr_data), 32'(mod_q)));
  end

  assign rej_evt_o = per_bad || cmp_bad || pol_bad;
  assign restart_o = (sel_per && !per_bad) || sel_psc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= CW'(DEF_MOD);
      pend_q <= '0;
      act_q  <= '0;
      pol_q  <= '0;
      psc_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= rej_evt_o;
      if (sel_per && !per_bad) mod_q <= CW'(wr_data);
      if (sel_psc)             psc_q <= wr_data[PSW-1:0];
      if (sel_cmp && !cmp_bad) pend_q[wr_idx] <= cmp_new;
      if (sel_pol && !pol_bad) pol_q[wr_idx]  <= wr_data[0];
      if (load_i)              act_q <= pend_q;
    end
  end

  assign mod_o     = mod_q;
  assign cmp_act_o = act_q;
  assign pol_o     = pol_q;
  assign psc_o     = psc_q;
  assign rej_o     = rej_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          pol_i,
  input  logic          run_i,
  output logic          pwm_o
);
  logic active;

  // active from count 0 until the count equals the compare value
  assign active = run_i && (cnt_i < cmp_i);
  assign pwm_o  = active ^ pol_i;

endmodule

// File: rtl/pwm_edge_multi.sv
module pwm_edge_multi #(
  parameter int NCH     = 4,
  parameter int CW      = 16,
  parameter int PSW     = 3,
  parameter int DEF_MOD = 999,
  localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [IW-1:0]  wr_idx,
  input  logic [CW:0]    wr_data,
  output logic [NCH-1:0] pwm_o,
  output logic           wrap_o,
  output logic           wr_rej_o
);

  // named internal events, observed by the bound checker
  logic                   tick;
  logic                   running;
  logic                   restart;
  logic                   wrap_evt;
  logic                   load;
  logic                   rej_evt;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          mod_q;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [NCH-1:0]         pol;
  logic [PSW-1:0]         psc;

  // compares move to the active copy at a wrap or during the halt clock
  assign load = wrap_evt || !running;

  pwm_regs #(.NCH(NCH), .CW(CW), .PSW(PSW), .DEF_MOD(DEF_MOD)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .load_i    (load),
    .mod_o     (mod_q),
    .cmp_act_o (cmp_act),
    .pol_o     (pol),
    .psc_o     (psc),
    .restart_o (restart),
    .rej_evt_o (rej_evt),
    .rej_o     (wr_rej_o)
  );

  pwm_prescaler #(.PSW(PSW)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (restart),
    .en_i   (running),
    .exp_i  (psc),
    .tick_o (tick)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .tick_i     (tick),
    .mod_i      (mod_q),
    .cnt_o      (cnt),
    .running_o  (running),
    .wrap_evt_o (wrap_evt),
    .wrap_o     (wrap_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .cnt_i (cnt),
      .cmp_i (cmp_act[g]),
      .pol_i (pol[g]),
      .run_i (running),
      .pwm_o (pwm_o[g])
    );
  end

endmodule

// File: rtl/pwm_edge_multi_chk.sv
module pwm_edge_multi_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   running,
  input logic                   restart,
  input logic                   load,
  input logic                   rej_evt,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          mod_q,
  input logic [NCH-1:0][CW-1:0] cmp_act,
  input logic [NCH-1:0]         pol,
  input logic [NCH-1:0]         pwm_o,
  input logic                   wrap_o
);

  a_r2_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= mod_q));

  a_r8_halt_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!running && cnt == '0));

  a_r8_halt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> running);

  a_r8_halt_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_o == pol));

  a_r6_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_act));

  a_r9_reject_keeps_mod: assert property (@(posedge clk) disable iff (!rst_n)
    rej_evt |=> $stable(mod_q));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cmp_act[g] > mod_q) |-> (pwm_o[g] != pol[g]));

    a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[g] == '0) |-> (pwm_o[g] == pol[g]));
  end

endmodule

bind pwm_edge_multi pwm_edge_multi_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .running (running),
  .restart (restart),
  .load    (load),
  .rej_evt (rej_evt),
  .cnt     (cnt),
  .mod_q   (mod_q),
  .cmp_act (cmp_act),
  .pol     (pol),
  .pwm_o   (pwm_o),
  .wrap_o  (wrap_o)
);

// File: tb/tb_pwm_edge_multi.sv
module tb_pwm_edge_multi;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int PSW  = 2;
  localparam int DEFM = 5;
  localparam int IW   = 2;
  localparam int ALL1 = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_sel = '0;
  logic [IW-1:0]  wr_idx = '0;
  logic [CW:0]    wr_data = '0;
  logic [NCH-1:0] pwm_o;
  logic           wrap_o;
  logic           wr_rej_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_pend[NCH];
  int m_act[NCH];
  logic [NCH-1:0] m_pol;
  int m_P;
  int m_D;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_multi #(.NCH(NCH), .CW(CW), .PSW(PSW), .DEF_MOD(DEFM)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .pwm_o(pwm_o), .wrap_o(wrap_o), .wr_rej_o(wr_rej_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic do_write(input int sel, input int idx, input int val);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_idx = IW'(idx); wr_data = (CW+1)'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input int v);
    do_write(1, ch, v);
    m_pend[ch] = (v == m_P) ? m_P + 1 : v;
  endtask

  task automatic wr_pol(input int ch, input bit b);
    do_write(2, ch, int'(b));
    m_pol[ch] = b;
  endtask

  // period (sel 0) or prescale (sel 3) write, with halt-clock checks (R8)
  task automatic restart_with(input int sel, input int v);
    do_write(sel, 0, v);
    chk(wr_rej_o == 1'b0, "R9 accepted write flagged", int'(wr_rej_o), 0);
    chk(pwm_o == m_pol, "R8 halt outputs inactive", int'(pwm_o), int'(m_pol));
    chk(wrap_o == 1'b0, "R8 no wrap at halt", int'(wrap_o), 0);
    if (sel == 0) m_P = v; else m_D = 1 << v;
    for (int c = 0; c < NCH; c++) m_act[c] = m_pend[c];
    @(negedge clk);
  endtask

  task automatic wait_wrap();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wrap_o && n < 5000);
    chk(wrap_o == 1'b1, "R2 wrap pulse seen", int'(wrap_o), 1);
    for (int c = 0; c < NCH; c++) m_act[c] = m_pend[c];
  endtask

  // caller stands at the negedge of the first clock of a period
  task automatic check_period(input string tag);
    int n;
    int mism[NCH];
    int hi[NCH];
    int len[NCH];
    n = (m_P + 1) * m_D;
    for (int c = 0; c < NCH; c++) begin
      mism[c] = 0; hi[c] = 0;
      len[c] = (m_act[c] > m_P) ? m_P + 1 : m_act[c];
    end
    for (int j = 0; j < n; j++) begin
      for (int c = 0; c < NCH; c++) begin
        if (pwm_o[c] != ((((j / m_D) < len[c]) ? 1'b1 : 1'b0) ^ m_pol[c])) mism[c]++;
        if (pwm_o[c] ^ m_pol[c]) hi[c]++;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    for (int c = 0; c < NCH; c++)
      chk(mism[c] == 0, $sformatf("%s ch%0d active clocks", tag, c), hi[c], len[c] * m_D);
    chk(wrap_o == 1'b1, $sformatf("R2 %s period length", tag), int'(wrap_o), 1);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin m_pend[c] = 0; m_act[c] = 0; end
    m_pol = '0; m_P = DEFM; m_D = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwm_o == '0, "R1 outputs low", int'(pwm_o), 0);
    chk(wrap_o == 1'b0, "R1 wrap low", int'(wrap_o), 0);
    chk(wr_rej_o == 1'b0, "R1 reject low", int'(wr_rej_o), 0);
    wait_wrap();
    check_period("R1/R3 default period zero duty");

    // R2/R3/R4/R5/R7/R11 sweep over period, prescale, compares, polarity
    for (int e = 0; e < 3; e++) begin
      for (int p = 1; p <= 6; p++) begin
        restart_with(3, e);
        restart_with(0, p);
        for (int k = 0; k < 2; k++) begin
          for (int c = 0; c < NCH; c++) wr_cmp(c, (2 * c + k + p) % (p + 3));
          for (int c = 0; c < NCH; c++) wr_pol(c, 1'((p + k + c) & 1));
          wait_wrap();
          check_period($sformatf("R3/R4/R5/R7 P=%0d E=%0d", p, e));
        end
      end
    end

    // R5 explicit: pulse equal to period gives full duty, one less does not
    restart_with(3, 0);
    restart_with(0, 7);
    for (int c = 0; c < NCH; c++) wr_pol(c, 1'b0);
    wr_cmp(0, 7); wr_cmp(1, 6); wr_cmp(2, 0); wr_cmp(3, 200);
    wait_wrap();
    check_period("R5/R4 equal and above period");

    // R6 compare write inside a running period waits for the boundary
    wr_cmp(0, 2); wr_cmp(1, 2); wr_cmp(2, 2); wr_cmp(3, 2);
    wait_wrap();
    check_period("R6 baseline");
    wr_en = 1'b1; wr_sel = 2'd1; wr_idx = 2'd0; wr_data = 9'd5;
    m_pend[0] = 5;
    check_period("R6 old value kept mid period");
    for (int c = 0; c < NCH; c++) m_act[c] = m_pend[c];
    check_period("R6 new value after boundary");

    // R8 restart loads pending compares from count zero
    wr_cmp(1, 4);
    restart_with(0, 4);
    check_period("R8 restart from zero");

    // R7 polarity acts on the next clock
    wr_cmp(2, 0);
    wait_wrap();
    check_period("R7 setup");
    wr_pol(2, 1'b1);
    chk(pwm_o[2] == 1'b1, "R7 inverted next clock", int'(pwm_o[2]), 1);
    wait_wrap();
    check_period("R7 inverted period");

    // R9 illegal periods refused, period kept
    do_write(0, 0, 0);
    chk(wr_rej_o == 1'b1, "R9 period zero refused", int'(wr_rej_o), 1);
    @(negedge clk);
    chk(wr_rej_o == 1'b0, "R9 reject one clock", int'(wr_rej_o), 0);
    do_write(0, 0, ALL1);
    chk(wr_rej_o == 1'b1, "R9 all-ones period refused", int'(wr_rej_o), 1);
    do_write(0, 0, ALL1 + 1);
    chk(wr_rej_o == 1'b1, "R9 oversize period refused", int'(wr_rej_o), 1);
    wait_wrap();
    check_period("R9 period unchanged");

    // R10 oversize compare refused, pulse unchanged
    do_write(1, 1, ALL1 + 1);
    chk(wr_rej_o == 1'b1, "R10 oversize compare refused", int'(wr_rej_o), 1);
    wait_wrap();
    check_period("R10 pulse unchanged");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule